// File: doc/BRIEF.md
# Data Cache Maintenance Engine

This block carries out maintenance commands on the tag and state array of a data cache. The cache holds 16 KB in 4 ways with 32-byte (8-word) lines, which gives 128 sets. A processor issues each command as a coprocessor register write. The command carries a 4-bit sub-register code, a 3-bit secondary opcode and a 32-bit operand. The engine decodes the command and picks one line, either by looking the operand up as a virtual address or by taking set and way directly from the operand. It then invalidates, cleans or cleans-and-invalidates that line. Cleaning a dirty line writes it back through a request/acknowledge port.

Three commands do not target a single line. The test-and-clean read is meant to be called in a software loop. Each call cleans at most one dirty line and returns a flag that says whether the whole cache is now clean. A second variant of it also invalidates every line. The drain command holds the command port until the write buffer reports empty. The wait-for-interrupt command holds the port until an interrupt arrives. The array is read combinationally for the set on `arr_set`. State is written back through a per-way mask in the same cycle.

Top module: `dcache_maint_engine`

## Requirements
- R1: Out of reset, `cmd_ready` is 1 and `wb_req`, `rsp_valid` and `arr_wmask` are 0. While `cmd_ready` is 1, no array write and no write-back request are made.
- R2: In the operand, bits [31:12] hold the tag, bits [11:5] hold the set, and bits [31:30] hold the way for set/way commands. Bits [4:0] are ignored, and for set/way commands bits [29:12] are ignored as well. A write-back address is {tag, set, 5'b0}.
- R3: Sub-register 6 with opcode 2 invalidates the line at the set/way, clearing both valid and dirty. It never writes back.
- R4: Sub-register 10 with opcode 1 (virtual address) or opcode 2 (set/way) cleans a line. A valid dirty line gets one write-back request, and on the acknowledge cycle the line is rewritten valid=1, dirty=0. A line that is not both valid and dirty is left unchanged and nothing is written back.
- R5: Sub-register 14 with opcode 1 or 2 cleans the line as in R4 and then leaves it invalid and clean. A valid clean line is invalidated without a write-back.
- R6: A virtual-address lookup hits the lowest-numbered valid way whose tag matches. A miss in every way changes nothing and writes nothing back.
- R7: Sub-register 10 with opcode 3 scans sets in ascending order, lowest way first. It writes back the first valid dirty line found and marks it clean, then responds with flag 0. If no such line exists, it responds with flag 1.
- R8: Sub-register 14 with opcode 3 works like R7 but leaves the written-back line invalid. It also invalidates every set it scans that holds no dirty line, so a flag of 1 means every line is invalid.
- R9: Sub-register 10 with opcode 4 keeps `cmd_ready` low until `wb_empty` is 1.
- R10: Sub-register 0 with opcode 4 keeps `cmd_ready` low until `irq` is 1.
- R11: Any other code is accepted with no effect, and `cmd_ready` stays 1.
- R12: `wb_req` and `wb_addr` hold steady until `wb_ack`.
- R13: `rsp_valid` is a one-cycle pulse, given only on completion of the R7/R8 commands, in the first cycle `cmd_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; command accepted when valid |
| cmd_crm | input | 4 | Sub-register code |
| cmd_op2 | input | 3 | Secondary opcode |
| cmd_operand | input | 32 | Address or set/way operand |
| rsp_valid | output | 1 | Test-and-clean result pulse |
| rsp_flag | output | 1 | 1 when no dirty line remains |
| arr_set | output | 7 | Set being read and written |
| arr_tag | input | 80 | Tags of the 4 ways, way 0 in the low bits |
| arr_valid | input | 4 | Valid bits of the addressed set |
| arr_dirty | input | 4 | Dirty bits of the addressed set |
| arr_wmask | output | 4 | Ways to rewrite this cycle |
| arr_wvalid | output | 1 | Valid value written to masked ways |
| arr_wdirty | output | 1 | Dirty value written to masked ways |
| wb_req | output | 1 | Line write-back request |
| wb_addr | output | 32 | Line-aligned write-back address |
| wb_ack | input | 1 | Write-back accepted |
| wb_empty | input | 1 | Write buffer empty |
| irq | input | 1 | Interrupt pending |

## Verification
The line commands are driven with random operands against a randomly filled array. Some operands are built from tags that are present and some from random tags, so hits are told apart from misses. Set/way operands carry junk in the ignored bits, which tells correct field slicing apart from wrong slicing. Directed cases pin down the outcome for each line state: dirty lines must be written back, clean lines must not be, and invalidate-only must discard. The test-and-clean loops run until the flag rises, which shows whether exactly one line is cleaned per call, in ascending order. The drain and interrupt waits are held for several cycles, which shows whether release follows the right input.

// File: rtl/dcache_maint_engine.sv
module dcache_maint_engine #(
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  localparam int SW = $clog2(SETS),
  localparam int AW = $clog2(WAYS),
  localparam int OW = $clog2(LINE_BYTES),
  localparam int TW = ADDR_W - SW - OW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_crm,
  input  logic [2:0]        cmd_op2,
  input  logic [ADDR_W-1:0] cmd_operand,
  output logic              rsp_valid,
  output logic              rsp_flag,
  output logic [SW-1:0]     arr_set,
  input  logic [WAYS*TW-1:0] arr_tag,
  input  logic [WAYS-1:0]   arr_valid,
  input  logic [WAYS-1:0]   arr_dirty,
  output logic [WAYS-1:0]   arr_wmask,
  output logic              arr_wvalid,
  output logic              arr_wdirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  input  logic              wb_empty,
  input  logic              irq
);

  typedef enum logic [2:0] {ST_IDLE, ST_LINE, ST_SCAN, ST_WB, ST_DRAIN, ST_WFI} st_t;

  st_t            state;
  logic [SW-1:0]  cur_set;
  logic [AW-1:0]  cur_way;
  logic [TW-1:0]  lat_tag, wb_tag;
  logic           by_sw, do_cln, do_inv, in_scan;

  wire crm_cln  = cmd_crm == 4'd10;
  wire crm_ci   = cmd_crm == 4'd14;
  wire line_op  = (cmd_crm == 4'd6 && cmd_op2 == 3'd2) ||
                  ((crm_cln || crm_ci) && (cmd_op2 == 3'd1 || cmd_op2 == 3'd2));
  wire scan_op  = (crm_cln || crm_ci) && cmd_op2 == 3'd3;
  wire drain_op = crm_cln && cmd_op2 == 3'd4;
  wire wfi_op   = cmd_crm == 4'd0 && cmd_op2 == 3'd4;

  logic [WAYS-1:0] hitv, dirtyv;
  logic [AW-1:0]   hit_way, dirty_way, tw;
  logic            found, sel_dirty, any_dirty;

  always_comb begin
    hit_way   = '0;
    dirty_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      hitv[w]   = arr_valid[w] && arr_tag[w*TW +: TW] == lat_tag;
      dirtyv[w] = arr_valid[w] && arr_dirty[w];
      if (hitv[w])   hit_way   = AW'(w);
      if (dirtyv[w]) dirty_way = AW'(w);
    end
  end

  assign any_dirty = |dirtyv;
  assign found     = by_sw || |hitv;
  assign tw        = by_sw ? cur_way : hit_way;
  assign sel_dirty = dirtyv[tw];

  assign cmd_ready = state == ST_IDLE;
  assign arr_set   = cur_set;
  assign wb_req    = state == ST_WB;
  assign wb_addr   = {wb_tag, cur_set, {OW{1'b0}}};

  always_comb begin
    arr_wmask  = '0;
    arr_wvalid = 1'b0;
    arr_wdirty = 1'b0;
    case (state)
      ST_LINE: if (found && do_inv && !(do_cln && sel_dirty)) arr_wmask[tw] = 1'b1;
      ST_SCAN: if (!any_dirty && do_inv) arr_wmask = '1;
      ST_WB: if (wb_ack) begin
        arr_wmask[cur_way] = 1'b1;
        arr_wvalid         = !do_inv;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_set   <= '0;
      cur_way   <= '0;
      lat_tag   <= '0;
      wb_tag    <= '0;
      by_sw     <= 1'b0;
      do_cln    <= 1'b0;
      do_inv    <= 1'b0;
      in_scan   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_flag  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          if (line_op) begin
            cur_set <= cmd_operand[OW +: SW];
            cur_way <= cmd_operand[ADDR_W-1 -: AW];
            lat_tag <= cmd_operand[ADDR_W-1 -: TW];
            by_sw   <= cmd_op2 == 3'd2;
            do_cln  <= cmd_crm != 4'd6;
            do_inv  <= cmd_crm != 4'd10;
            state   <= ST_LINE;
          end else if (scan_op) begin
            cur_set <= '0;
            do_inv  <= crm_ci;
            state   <= ST_SCAN;
          end else if (drain_op) begin
            state <= ST_DRAIN;
          end else if (wfi_op) begin
            state <= ST_WFI;
          end
        end
        ST_LINE: begin
          if (found && do_cln && sel_dirty) begin
            cur_way <= tw;
            wb_tag  <= arr_tag[tw*TW +: TW];
            in_scan <= 1'b0;
            state   <= ST_WB;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (any_dirty) begin
            cur_way <= dirty_way;
            wb_tag  <= arr_tag[dirty_way*TW +: TW];
            in_scan <= 1'b1;
            state   <= ST_WB;
          end else if (cur_set == SW'(SETS-1)) begin
            rsp_valid <= 1'b1;
            rsp_flag  <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cur_set <= cur_set + 1'b1;
          end
        end
        ST_WB: if (wb_ack) begin
          if (in_scan) begin
            rsp_valid <= 1'b1;
            rsp_flag  <= 1'b0;
          end
          state <= ST_IDLE;
        end
        ST_DRAIN: if (wb_empty) state <= ST_IDLE;
        ST_WFI:   if (irq) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcache_maint_checker.sv
module dcache_maint_checker #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_crm,
  input logic [2:0]        cmd_op2,
  input logic              rsp_valid,
  input logic [WAYS-1:0]   arr_wmask,
  input logic              wb_req,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_ack,
  input logic              wb_empty,
  input logic              irq
);

  wire acc = cmd_valid && cmd_ready;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (arr_wmask == '0 && !wb_req)); // R1

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr))); // R12

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R13

  AST_RSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready); // R13

  AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_crm == 4'd10 && cmd_op2 == 3'd4 && !wb_empty) |=> !cmd_ready); // R9

  AST_WFI_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_crm == 4'd0 && cmd_op2 == 3'd4 && !irq) |=> !cmd_ready); // R10

  AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_crm == 4'd5) |=> (cmd_ready && arr_wmask == '0 && !wb_req)); // R11

endmodule

bind dcache_maint_engine dcache_maint_checker #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dcache_maint_engine_test.sv
module dcache_maint_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_ready;
  logic [3:0]  cmd_crm = '0;
  logic [2:0]  cmd_op2 = '0;
  logic [31:0] cmd_operand = '0;
  logic        rsp_valid, rsp_flag;
  logic [6:0]  arr_set;
  logic [79:0] arr_tag;
  logic [3:0]  arr_valid, arr_dirty, arr_wmask;
  logic        arr_wvalid, arr_wdirty, wb_req, wb_ack = 1'b0;
  logic [31:0] wb_addr;
  logic        wb_empty = 1'b1, irq = 1'b0;

  dcache_maint_engine uut (.*);

  logic [19:0] mtag [128][4];
  bit mv [128][4], md [128][4], ev [128][4], ed [128][4];
  logic [31:0] wb_log[$], exp_log[$];
  int checks = 0, fails = 0;

  always_comb
    for (int w = 0; w < 4; w++) begin
      arr_tag[w*20 +: 20] = mtag[arr_set][w];
      arr_valid[w] = mv[arr_set][w];
      arr_dirty[w] = md[arr_set][w];
    end

  always @(posedge clk) begin
    if (rst_n) for (int w = 0; w < 4; w++)
      if (arr_wmask[w]) begin
        mv[arr_set][w] <= arr_wvalid;
        md[arr_set][w] <= arr_wdirty;
      end
    if (wb_req && wb_ack) wb_log.push_back(wb_addr);
    wb_ack <= rst_n && wb_req && !wb_ack && ($urandom % 3 == 0);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(int dmod);
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        mtag[s][w] = {18'($urandom), 2'(w)};
        mv[s][w] = ($urandom % 4) != 0;
        md[s][w] = ($urandom % dmod) == 0;
        ev[s][w] = mv[s][w];
        ed[s][w] = md[s][w];
      end
  endtask

  task automatic cmp(string req);
    int m = 0;
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++)
        if (mv[s][w] != ev[s][w] || md[s][w] != ed[s][w]) m++;
    chk(m == 0, req, "line state mismatches", m, 0);
    chk(wb_log.size() == exp_log.size(), req, "write-back count", wb_log.size(), exp_log.size());
    if (wb_log.size() == exp_log.size())
      for (int i = 0; i < wb_log.size(); i++)
        chk(wb_log[i] == exp_log[i], req, "write-back address", wb_log[i], exp_log[i]);
    wb_log.delete();
    exp_log.delete();
  endtask

  task automatic ref_line(logic [31:0] op, bit sw, bit cln, bit inv);
    int s = int'(op[11:5]);
    int t = -1;
    if (sw) t = int'(op[31:30]);
    else for (int w = 3; w >= 0; w--) if (ev[s][w] && mtag[s][w] == op[31:12]) t = w;
    if (t < 0) return;
    if (cln && ev[s][t] && ed[s][t]) begin
      exp_log.push_back({mtag[s][t], 7'(s), 5'b0});
      ed[s][t] = 0;
      if (inv) ev[s][t] = 0;
    end else if (inv) begin
      ev[s][t] = 0;
      ed[s][t] = 0;
    end
  endtask

  task automatic ref_op(logic [3:0] crm, logic [2:0] op2, logic [31:0] op);
    if (crm == 6 && op2 == 2) ref_line(op, 1, 0, 1);
    else if ((crm == 10 || crm == 14) && (op2 == 1 || op2 == 2))
      ref_line(op, op2 == 2, 1, crm == 14);
  endtask

  function automatic bit ref_scan(bit inv);
    for (int s = 0; s < 128; s++) begin
      for (int w = 0; w < 4; w++)
        if (ev[s][w] && ed[s][w]) begin
          exp_log.push_back({mtag[s][w], 7'(s), 5'b0});
          ed[s][w] = 0;
          if (inv) ev[s][w] = 0;
          return 1'b0;
        end
      if (inv) for (int w = 0; w < 4; w++) begin ev[s][w] = 0; ed[s][w] = 0; end
    end
    return 1'b1;
  endfunction

  task automatic issue(logic [3:0] crm, logic [2:0] op2, logic [31:0] op,
                       output bit rv, output bit rf, output int lat);
    @(negedge clk);
    cmd_valid = 1; cmd_crm = crm; cmd_op2 = op2; cmd_operand = op;
    @(negedge clk);
    cmd_valid = 0;
    lat = 0;
    while (!cmd_ready) begin @(negedge clk); lat++; end
    rv = rsp_valid;
    rf = rsp_flag;
  endtask

  task automatic scan_loop(bit inv, string req);
    bit rv, rf, ef;
    int lat, n = 0;
    do begin
      issue(inv ? 4'd14 : 4'd10, 3'd3, 32'd0, rv, rf, lat);
      ef = ref_scan(inv);
      chk(rv == 1, "R13", "response pulse after scan", rv, 1);
      chk(rf == ef, req, "test-and-clean flag", rf, ef);
      cmp(req);
      n++;
    end while (!rf && n < 400);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit rv, rf;
    int lat, s, w;
    logic [31:0] op;
    logic [3:0] crm;
    logic [2:0] op2;
    void'($urandom(32'd1234));
    fill(3);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1, "R1", "ready in reset", cmd_ready, 1);
    chk(wb_req == 0 && rsp_valid == 0 && arr_wmask == 0, "R1", "quiet outputs in reset",
        {wb_req, rsp_valid, arr_wmask}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R1", "ready after reset", cmd_ready, 1);

    // R4 / R2: clean by virtual address on a dirty line
    mv[33][1] = 1; md[33][1] = 1; ev[33][1] = 1; ed[33][1] = 1;
    op = {mtag[33][1], 7'd33, 3'd5, 2'b0};
    issue(4'd10, 3'd1, op, rv, rf, lat);
    chk(wb_log.size() == 1, "R4", "dirty clean write-back count", wb_log.size(), 1);
    if (wb_log.size() == 1)
      chk(wb_log[0] == {mtag[33][1], 7'd33, 5'b0}, "R2", "write-back address",
          wb_log[0], {mtag[33][1], 7'd33, 5'b0});
    chk(mv[33][1] == 1 && md[33][1] == 0, "R4", "line valid and clean", {mv[33][1], md[33][1]}, 2);
    ref_op(4'd10, 3'd1, op);
    cmp("R4");

    // R3 / R2: set/way invalidate of a dirty line with junk in ignored bits
    mv[90][3] = 1; md[90][3] = 1; ev[90][3] = 1; ed[90][3] = 1;
    op = {2'd3, 18'h3ffff, 7'd90, 5'b11100};
    issue(4'd6, 3'd2, op, rv, rf, lat);
    chk(mv[90][3] == 0 && md[90][3] == 0, "R3", "line invalidated", {mv[90][3], md[90][3]}, 0);
    chk(wb_log.size() == 0, "R3", "no write-back on invalidate", wb_log.size(), 0);
    ref_op(4'd6, 3'd2, op);
    cmp("R2");

    // R6: miss with every way dirty
    for (int k = 0; k < 4; k++) begin mv[7][k] = 1; md[7][k] = 1; ev[7][k] = 1; ed[7][k] = 1; end
    op = {mtag[7][0] ^ 20'h80000, 7'd7, 5'b0};
    issue(4'd14, 3'd1, op, rv, rf, lat);
    cmp("R6");

    // R5: clean-and-invalidate on a clean valid line
    mv[64][2] = 1; md[64][2] = 0; ev[64][2] = 1; ed[64][2] = 0;
    op = {2'd2, 18'h0, 7'd64, 5'b0};
    issue(4'd14, 3'd2, op, rv, rf, lat);
    chk(mv[64][2] == 0, "R5", "clean line invalidated", mv[64][2], 0);
    ref_op(4'd14, 3'd2, op);
    cmp("R5");

    // R11: undefined code
    issue(4'd5, 3'd0, 32'hffff_ffff, rv, rf, lat);
    chk(lat == 0, "R11", "undefined code stall cycles", lat, 0);
    cmp("R11");

    // R9: drain waits for empty write buffer
    @(negedge clk);
    wb_empty = 0; cmd_valid = 1; cmd_crm = 4'd10; cmd_op2 = 3'd4; cmd_operand = 0;
    @(negedge clk);
    cmd_valid = 0;
    repeat (4) @(negedge clk);
    chk(cmd_ready == 0, "R9", "stalled while buffer busy", cmd_ready, 0);
    wb_empty = 1;
    @(negedge clk);
    chk(cmd_ready == 1, "R9", "released when empty", cmd_ready, 1);

    // R10: wait for interrupt
    cmd_valid = 1; cmd_crm = 4'd0; cmd_op2 = 3'd4;
    @(negedge clk);
    cmd_valid = 0;
    repeat (6) @(negedge clk);
    chk(cmd_ready == 0, "R10", "stalled without interrupt", cmd_ready, 0);
    irq = 1;
    @(negedge clk);
    irq = 0;
    chk(cmd_ready == 1, "R10", "released by interrupt", cmd_ready, 1);

    // Random line commands
    for (int i = 0; i < 400; i++) begin
      int k = $urandom % 8;
      s = $urandom % 128;
      w = $urandom % 4;
      case (k)
        0: begin crm = 6;  op2 = 2; end
        1: begin crm = 10; op2 = 1; end
        2: begin crm = 10; op2 = 2; end
        3: begin crm = 14; op2 = 1; end
        4: begin crm = 14; op2 = 2; end
        5: begin crm = 5;  op2 = 0; end
        6: begin crm = 6;  op2 = 1; end
        default: begin crm = 7; op2 = 3; end
      endcase
      if (op2 == 1)
        op = {($urandom % 4 != 0) ? mtag[s][w] : 20'($urandom), 7'(s), 3'($urandom), 2'b0};
      else
        op = {2'(w), 18'($urandom), 7'(s), 3'($urandom), 2'b0};
      issue(crm, op2, op, rv, rf, lat);
      chk(rv == 0, "R13", "no response for line command", rv, 0);
      ref_op(crm, op2, op);
      if (k == 5 || k > 5) begin
        chk(lat == 0, "R11", "undefined code stall cycles", lat, 0);
        cmp("R11");
      end else if (k == 0) cmp("R3");
      else if (k < 3) cmp("R4");
      else cmp("R5");
    end

    // R7: test-and-clean loop
    fill(16);
    scan_loop(1'b0, "R7");

    // R8: test-clean-and-invalidate loop
    fill(16);
    scan_loop(1'b1, "R8");
    begin
      int live = 0;
      for (int a = 0; a < 128; a++) for (int b = 0; b < 4; b++) if (mv[a][b]) live++;
      chk(live == 0, "R8", "valid lines after final flag", live, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule